// File: doc/BRIEF.md
# Trip-Point Alarm Output Controller

This block watches a running elapsed-time count and raises an alarm once that count reaches a programmed trip value. The result drives an active-low, open-drain alarm pin. The pin can work in one of two ways. In level mode it is held low for as long as the alarm is active. In flash mode it is pulled low in a burst of four short pulses, which suits an indicator LED or a downstream sampler. A polarity control can invert the alarm sense, so that the pin signals "not yet reached" instead of "reached".

The same pin can be given a second job as an input. In that case the controller never drives it, and passes its sampled level out as an external reset-enable. In flash mode a burst starts in three cases: when the alarm becomes active, on the first cycle after reset if the alarm is already active, and when someone holds the undriven pin low for a set time and then releases it. A trigger that arrives while a burst is running is dropped. All burst timing is counted in cycles of a base-tick enable. The default widths assume a half-millisecond tick, which gives 62.5 ms low pulses and 437.5 ms gaps, and a 500 ms hold before a press is recognised.

Top module: `trip_alarm_ctrl`

## Requirements
- R1: The alarm can be active only when the trip value is non-zero and the pin-function input `pin_as_input` is 0. Otherwise `alarm_flag` reads 0.
- R2: The match condition is `elapsed >= trip`, compared as unsigned numbers.
- R3: With `pol_inv` = 0 the alarm is active when the count matches. With `pol_inv` = 1 it is active while the count has not yet matched.
- R4: With `out_pulsed` = 0 (level mode), `pin_drive_low` is 1 exactly when the alarm is active. It follows the inputs with one cycle of latency.
- R5: With `out_pulsed` = 1, a burst drives `pin_drive_low` high for PULSES low phases of LOW_TICKS ticks each. Each low phase is followed by a gap of GAP_TICKS ticks, including a trailing gap after the last pulse. Only cycles with `base_tick` = 1 advance the timing. The first low phase appears in the cycle after the trigger.
- R6: In flash mode a burst is triggered when the alarm goes from inactive to active. The first cycle after reset counts as such a transition if the alarm is already active there.
- R7: A trigger of any kind that occurs while a burst is running is ignored. The running burst keeps its exact pattern.
- R8: In flash mode with the alarm active and the pin undriven, a burst is triggered when the pin has been sampled low for HOLD_TICKS ticks and is then seen high. A release after fewer ticks triggers nothing.
- R9: `alarm_flag` reads 1 while the alarm is active. A `flag_clr` pulse forces it to 0 in the following cycle without changing the pin drive. It reads 1 again afterwards if the alarm is still active.
- R10: With `pin_as_input` = 1, `pin_drive_low` is 0 and `ext_rst_en` follows `pin_in` with one cycle of latency. With `pin_as_input` = 0, `ext_rst_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle enable that times bursts and press holds |
| elapsed | input | CNT_W | Running elapsed-time count |
| trip | input | CNT_W | Programmed trip value; zero disables the alarm |
| pol_inv | input | 1 | 0: active from the match on; 1: active until the match |
| out_pulsed | input | 1 | 0: level mode; 1: flash (burst) mode |
| pin_as_input | input | 1 | 1: pin is an undriven reset-enable input |
| pin_in | input | 1 | Synchronised level seen on the pin |
| flag_clr | input | 1 | One-cycle clear of the alarm flag |
| pin_drive_low | output | 1 | 1 pulls the open-drain pin low |
| alarm_flag | output | 1 | Alarm-active status |
| ext_rst_en | output | 1 | Pin level when the pin is used as an input |

## Verification
The assertions assume that `pin_in` is already synchronised, and that `pin_in` reads low whenever the block drives the pin, as it would on a real open-drain line. The stimulus keeps `pin_in` high except during deliberate press intervals, which it only applies while the pin is undriven. The assertions also assume that `flag_clr` is a single-cycle pulse and that configuration inputs change only between bursts. The stimulus changes configuration only when no burst is in progress, with one exception: the count is deliberately dropped and restored inside a burst to test that a retrigger is ignored.

// File: rtl/alm_pkg.sv
package alm_pkg;
    typedef enum logic [1:0] {
        BST_IDLE = 2'd0,
        BST_LOW  = 2'd1,
        BST_GAP  = 2'd2
    } bst_state_e;
endpackage

// File: rtl/alm_match.sv
module alm_match #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] elapsed,
    input  logic [CNT_W-1:0] trip,
    input  logic             pol_inv,
    input  logic             pin_as_input,
    output logic             alarm_act
);
    logic monitor_on;
    logic reached;

    always_comb begin
        // Monitoring needs a programmed trip value and the pin in output use.
        monitor_on = (|trip) && !pin_as_input;
        reached    = (elapsed >= trip);
        alarm_act  = monitor_on && (pol_inv ? !reached : reached);
    end
endmodule

// File: rtl/alm_burst.sv
module alm_burst
    import alm_pkg::*;
#(
    parameter int LOW_TICKS = 125,
    parameter int GAP_TICKS = 875,
    parameter int PULSES    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic low_nx,
    output logic busy
);
    localparam int PH_MAX = (LOW_TICKS > GAP_TICKS) ? LOW_TICKS : GAP_TICKS;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int PN_W   = $clog2(PULSES + 1);

    typedef struct packed {
        bst_state_e      state;
        logic [PH_W-1:0] ph;
        logic [PN_W-1:0] pn;
    } bst_regs_t;

    bst_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            BST_IDLE: begin
                if (start) begin
                    d.state = BST_LOW;
                    d.ph    = '0;
                    d.pn    = '0;
                end
            end
            BST_LOW: begin
                if (tick) begin
                    if (q.ph == PH_W'(LOW_TICKS - 1)) begin
                        d.state = BST_GAP;
                        d.ph    = '0;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
            end
            BST_GAP: begin
                if (tick) begin
                    if (q.ph == PH_W'(GAP_TICKS - 1)) begin
                        d.ph = '0;
                        if (q.pn == PN_W'(PULSES - 1)) begin
                            d.state = BST_IDLE;
                            d.pn    = '0;
                        end else begin
                            d.state = BST_LOW;
                            d.pn    = q.pn + 1'b1;
                        end
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
            end
            default: d.state = BST_IDLE;
        endcase
        low_nx = (d.state == BST_LOW);
        busy   = (q.state != BST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= BST_IDLE;
            q.ph    <= '0;
            q.pn    <= '0;
        end else begin
            q <= d;
        end
    end

    logic [PN_W-1:0] pn_q;
    logic [PH_W-1:0] ph_q;
    logic            run_q;
    assign pn_q  = q.pn;
    assign ph_q  = q.ph;
    assign run_q = (q.state != BST_IDLE);

    // R5: the pulse index stays inside the burst length
    p_pulse_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pn_q < PN_W'(PULSES));

    // R5: the phase counter stays below the longer phase length
    p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q < PH_W'(PH_MAX));

    // R7: while running, the pulse index never moves backwards (no restart)
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (!run_q || (pn_q >= $past(pn_q))));
endmodule

// File: rtl/alm_hold_detect.sv
module alm_hold_detect #(
    parameter int HOLD_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic armed,
    input  logic pin_in,
    output logic press
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
    } hold_regs_t;

    hold_regs_t q, d;

    always_comb begin
        d = q;
        if (!armed || pin_in) begin
            d.cnt = '0;
        end else if (tick && (q.cnt != HW'(HOLD_TICKS))) begin
            d.cnt = q.cnt + 1'b1;
        end
        press = armed && pin_in && (q.cnt == HW'(HOLD_TICKS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    logic [HW-1:0] cnt_q;
    assign cnt_q = q.cnt;

    // R8: the hold counter saturates at the required hold length
    p_hold_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= HW'(HOLD_TICKS));

    // R8: a released pin always restarts the hold measurement
    p_hold_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_in |=> (cnt_q == '0));
endmodule

// File: rtl/trip_alarm_ctrl.sv
module trip_alarm_ctrl #(
    parameter int CNT_W      = 32,
    parameter int LOW_TICKS  = 125,
    parameter int GAP_TICKS  = 875,
    parameter int PULSES     = 4,
    parameter int HOLD_TICKS = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic [CNT_W-1:0] elapsed,
    input  logic [CNT_W-1:0] trip,
    input  logic             pol_inv,
    input  logic             out_pulsed,
    input  logic             pin_as_input,
    input  logic             pin_in,
    input  logic             flag_clr,
    output logic             pin_drive_low,
    output logic             alarm_flag,
    output logic             ext_rst_en
);
    typedef struct packed {
        logic alarm;
        logic flag;
        logic drive;
        logic rsten;
    } top_regs_t;

    top_regs_t q, d;

    logic alarm_act;
    logic press;
    logic start;
    logic low_nx;
    logic busy;
    logic armed;

    alm_match #(.CNT_W(CNT_W)) u_match (
        .elapsed      (elapsed),
        .trip         (trip),
        .pol_inv      (pol_inv),
        .pin_as_input (pin_as_input),
        .alarm_act    (alarm_act)
    );

    alm_hold_detect #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (base_tick),
        .armed  (armed),
        .pin_in (pin_in),
        .press  (press)
    );

    alm_burst #(
        .LOW_TICKS (LOW_TICKS),
        .GAP_TICKS (GAP_TICKS),
        .PULSES    (PULSES)
    ) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (base_tick),
        .start  (start),
        .low_nx (low_nx),
        .busy   (busy)
    );

    always_comb begin
        d       = q;
        armed   = !pin_as_input && !q.drive;
        // Rising alarm (reset clears q.alarm, so power-up counts) or a long press.
        start   = out_pulsed && !pin_as_input && alarm_act && !busy
                  && (!q.alarm || press);
        d.alarm = alarm_act;
        d.flag  = alarm_act && !flag_clr;
        d.drive = !pin_as_input && (out_pulsed ? low_nx : alarm_act);
        d.rsten = pin_as_input && pin_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pin_drive_low = q.drive;
    assign alarm_flag    = q.flag;
    assign ext_rst_en    = q.rsten;

    // R10: an input-mode pin is never driven
    p_input_mode_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_en |-> !pin_drive_low);

    // R9: a clear pulse leaves the flag at zero in the next cycle
    p_flag_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !alarm_flag);

    // R4: in level mode the pin drive and the status flag agree
    p_level_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(out_pulsed) && !$past(pin_as_input) && !$past(flag_clr))
        |-> (pin_drive_low == alarm_flag));

    // R1: no flag while the pin serves as an input
    p_flag_needs_output_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_en |-> !alarm_flag);
endmodule

// File: tb/trip_alarm_ctrl_tb.sv
module trip_alarm_ctrl_tb;
    localparam int CW    = 6;
    localparam int LT    = 2;
    localparam int GT    = 3;
    localparam int NP    = 4;
    localparam int HT    = 4;
    localparam int BURST = NP * (LT + GT);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          base_tick;
    logic [CW-1:0] elapsed;
    logic [CW-1:0] trip;
    logic          pol_inv;
    logic          out_pulsed;
    logic          pin_as_input;
    logic          pin_in;
    logic          flag_clr;
    logic          pin_drive_low;
    logic          alarm_flag;
    logic          ext_rst_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    trip_alarm_ctrl #(
        .CNT_W(CW), .LOW_TICKS(LT), .GAP_TICKS(GT), .PULSES(NP), .HOLD_TICKS(HT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .elapsed(elapsed),
        .trip(trip), .pol_inv(pol_inv), .out_pulsed(out_pulsed),
        .pin_as_input(pin_as_input), .pin_in(pin_in), .flag_clr(flag_clr),
        .pin_drive_low(pin_drive_low), .alarm_flag(alarm_flag), .ext_rst_en(ext_rst_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Samples one full burst starting at the negedge after the trigger edge.
    // At index pert the alarm is dropped for one cycle to retrigger mid-burst.
    task automatic trace(input string req, input int pert);
        for (int i = 0; i < BURST + 3; i++) begin
            chk(req, pin_drive_low, (i < BURST) && ((i % (LT + GT)) < LT));
            if (i == pert) elapsed = 6'd0;
            else if (i == pert + 1) elapsed = 6'd20;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; base_tick = 1'b1; elapsed = 6'd20; trip = 6'd10;
        pol_inv = 1'b0; out_pulsed = 1'b1; pin_as_input = 1'b0; pin_in = 1'b1;
        flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk("reset drive", pin_drive_low, 1'b0);
        chk("reset flag", alarm_flag, 1'b0);
        chk("reset rsten", ext_rst_en, 1'b0);

        // R6 power-up: alarm already active when reset releases
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 flag set in burst mode", alarm_flag, 1'b1);
        trace("R6 power-up burst / R5 shape", -10);

        // R6 activation trigger, with R7 retrigger inside the burst
        elapsed = 6'd0;
        repeat (2) @(negedge clk);
        chk("R6 idle while inactive", pin_drive_low, 1'b0);
        elapsed = 6'd20;
        @(negedge clk);
        trace("R7 retrigger ignored", 6);

        // R5 only ticks advance timing
        elapsed = 6'd0;
        repeat (2) @(negedge clk);
        base_tick = 1'b0;
        elapsed = 6'd20;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            chk("R5 frozen without tick", pin_drive_low, 1'b1);
            @(negedge clk);
        end
        base_tick = 1'b1;
        repeat (LT - 1) @(negedge clk);
        chk("R5 low lasts LOW_TICKS", pin_drive_low, 1'b1);
        @(negedge clk);
        chk("R5 gap after LOW_TICKS", pin_drive_low, 1'b0);
        repeat (BURST) @(negedge clk);
        chk("R5 burst ended", pin_drive_low, 1'b0);

        // R8 short press: no burst
        pin_in = 1'b0;
        repeat (HT - 1) @(negedge clk);
        pin_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R8 short press ignored", pin_drive_low, 1'b0);
        end
        // R8 full press then release
        pin_in = 1'b0;
        repeat (HT) @(negedge clk);
        pin_in = 1'b1;
        @(negedge clk);
        trace("R8 press triggers burst", -10);

        // R9 flag clear in level mode
        out_pulsed = 1'b0;
        @(negedge clk);
        chk("R4 level drive", pin_drive_low, 1'b1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R9 flag cleared", alarm_flag, 1'b0);
        chk("R9 drive unaffected", pin_drive_low, 1'b1);
        @(negedge clk);
        chk("R9 flag returns", alarm_flag, 1'b1);

        // R1 R2 R3 R4 R10 sweep in level mode
        for (int t = 0; t < 16; t++) begin
            for (int e = 0; e < 16; e++) begin
                for (int m = 0; m < 4; m++) begin
                    logic exp_act;
                    trip = 6'(t); elapsed = 6'(e);
                    pol_inv = m[0]; pin_as_input = m[1];
                    pin_in = e[0];
                    @(negedge clk);
                    exp_act = (t != 0) && !m[1] && (m[0] ? (e < t) : (e >= t));
                    chk("R1/R2/R3 flag", alarm_flag, exp_act);
                    chk("R4/R10 drive", pin_drive_low, exp_act);
                    chk("R10 rsten", ext_rst_en, m[1] && e[0]);
                end
            end
        end
        pin_in = 1'b1;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule